// File: doc/BRIEF.md
# Synchronous RAM with Selectable Read-Under-Write Policy

A simple dual-port memory with one write port and one read port on a shared clock. A write is stored at the clock edge where the write enable is high. A read request (read enable plus read address) is captured at a clock edge, and the data is presented during the following cycle. When the read enable was low at the previous edge, the read data is driven unknown (all X).

A compile-time parameter fixes what the read port returns when a read and a write target the same address at the same edge. Three policies are available: return the contents held before the write, return the data being written, or return an unknown value. The last choice makes a simulation expose any logic that relies on collision behaviour. Reads to any other address, and reads in a cycle with no write, return the same data under all three policies.

The memory contents have no reset and start uninitialised. The active-low reset clears only the read-valid state.

Top module: `ruw_sram`

## Requirements
- R1: The default build holds 256 words of 8 bits, addressed by 8-bit write and read addresses. Address 0 and address 255 can both be written and read back.
- R2: When wr_en is high at a rising edge, wr_data is stored at wr_addr. When wr_en is low, no location changes, even if wr_addr and wr_data are driven.
- R3: A read issued with rd_en high at a rising edge presents its data on rd_data during the cycle after that edge.
- R4: If rd_en was low at the previous rising edge, or no edge has passed since rst_n was released, rd_data is all X.
- R5: When the read address differs from the write address, or wr_en is low, the read returns the stored contents. This result is identical under every policy.
- R6: With MODE = RUW_WRITE_NEW (encoding 1, the default), a same-address read and write at one edge returns the written data.
- R7: With MODE = RUW_READ_OLD (encoding 0), a same-address read and write at one edge returns the value held before that write.
- R8: With MODE = RUW_UNSPEC (encoding 2), a same-address read and write at one edge returns all X.
- R9: Collisions on consecutive edges are each resolved independently under the selected policy, including a chain of writes to one address.
- R10: Asserting rst_n low clears the read-valid state but leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the read-valid state |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW (8) | Write address |
| wr_data | input | WIDTH (8) | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | AW (8) | Read address |
| rd_data | output | WIDTH (8) | Read data, valid in the cycle after a read request |

## Verification
The hardest case to reach is a collision whose outcome differs between policies. This needs a read and a write to the same address at the same edge, with a known older value at that address. It is also needed on consecutive edges, so that a stale old value can be told apart from the new one. The bench confines its random addresses to a small window after it has filled the whole array, so collisions happen often and always land on known contents. It also drives directed chains of writes to one address while reading that address, and runs three instances, one per policy, on the same stimulus against a reference array.

// File: rtl/ruw_sram_pkg.sv
package ruw_sram_pkg;

  typedef enum logic [1:0] {
    RUW_READ_OLD  = 2'd0,
    RUW_WRITE_NEW = 2'd1,
    RUW_UNSPEC    = 2'd2
  } ruw_mode_e;

  // Same-address access by both ports in one cycle
  function automatic logic addr_collide(input logic we, input logic re,
                                        input logic [31:0] wa,
                                        input logic [31:0] ra);
    return we && re && (wa == ra);
  endfunction

endpackage

// File: rtl/ruw_hit_detect.sv
module ruw_hit_detect #(
  parameter int AW = 8
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          hit
);
  import ruw_sram_pkg::*;

  logic [31:0] wa_ext, ra_ext;

  always_comb begin
    wa_ext = '0;
    ra_ext = '0;
    wa_ext[AW-1:0] = wr_addr;
    ra_ext[AW-1:0] = rd_addr;
    hit = addr_collide(wr_en, rd_en, wa_ext, ra_ext);
  end

endmodule

// File: rtl/ruw_store.sv
module ruw_store #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    look_addr,
  output logic [WIDTH-1:0] look_data,
  input  logic [AW-1:0]    peek_addr,
  output logic [WIDTH-1:0] peek_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  // Contents ahead of the edge: used for read-old capture
  assign look_data = mem_q[look_addr];
  // Contents after the edge: used for registered-address lookup
  assign peek_data = mem_q[peek_addr];

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/ruw_read_path.sv
module ruw_read_path
  import ruw_sram_pkg::*;
#(
  parameter ruw_mode_e MODE  = RUW_WRITE_NEW,
  parameter int        WIDTH = 8,
  parameter int        AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             hit,
  input  logic [WIDTH-1:0] fresh_data,
  input  logic [WIDTH-1:0] look_data,
  input  logic [WIDTH-1:0] peek_data,
  output logic [AW-1:0]    peek_addr,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  localparam logic [WIDTH-1:0] UNKNOWN = {WIDTH{1'bx}};

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) addr_q <= rd_addr;
  end

  assign peek_addr = addr_q;

  generate
    if (MODE == RUW_READ_OLD) begin : g_read_old
      logic [WIDTH-1:0] data_q;
      always_ff @(posedge clk) begin
        if (rd_en) data_q <= look_data;
      end
      assign rd_data = rd_valid ? data_q : UNKNOWN;

      // R7
      old_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rd_data === $past(look_data));
    end else if (MODE == RUW_UNSPEC) begin : g_unspec
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
      end
      assign rd_data = (rd_valid && !hit_q) ? peek_data : UNKNOWN;

      // R8
      x_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rd_data === UNKNOWN);
    end else begin : g_write_new
      assign rd_data = rd_valid ? peek_data : UNKNOWN;

      // R6
      new_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rd_data === $past(fresh_data));
    end
  endgenerate

  // R4
  idle_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data === UNKNOWN);

endmodule

// File: rtl/ruw_sram.sv
module ruw_sram
  import ruw_sram_pkg::*;
#(
  parameter ruw_mode_e MODE  = RUW_WRITE_NEW,
  parameter int        DEPTH = 256,
  parameter int        WIDTH = 8,
  parameter int        AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic             hit;
  logic             rd_valid;
  logic [AW-1:0]    peek_addr;
  logic [WIDTH-1:0] look_data;
  logic [WIDTH-1:0] peek_data;

  ruw_hit_detect #(.AW(AW)) u_hit (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .hit     (hit)
  );

  ruw_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .look_addr (rd_addr),
    .look_data (look_data),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  ruw_read_path #(.MODE(MODE), .WIDTH(WIDTH), .AW(AW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .hit        (hit),
    .fresh_data (wr_data),
    .look_data  (look_data),
    .peek_data  (peek_data),
    .peek_addr  (peek_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  // R5 and R3: a clean read shows the pre-edge contents one cycle later
  plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rd_data === $past(look_data));

  // R3
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/ruw_sram_test.sv
module ruw_sram_test;
  import ruw_sram_pkg::*;

  localparam int DEPTH = 256;
  localparam int WIDTH = 8;
  localparam int AW    = 8;
  localparam logic [WIDTH-1:0] XV = {WIDTH{1'bx}};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic [WIDTH-1:0] q_wf, q_ro, q_ud;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [WIDTH-1:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  ruw_sram #(.MODE(RUW_WRITE_NEW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_wf));

  ruw_sram #(.MODE(RUW_READ_OLD)) uut_ro (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_ro));

  ruw_sram #(.MODE(RUW_UNSPEC)) uut_ud (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(q_ud));

  function automatic logic [WIDTH-1:0] exp_for(input ruw_mode_e m,
      input logic we, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd,
      input logic re, input logic [AW-1:0] ra, input logic [WIDTH-1:0] old);
    if (!re) return XV;
    if (we && wa == ra) begin
      case (m)
        RUW_WRITE_NEW: return wd;
        RUW_READ_OLD:  return old;
        default:       return XV;
      endcase
    end
    return old;
  endfunction

  task automatic check(input string req, input string who,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, who, act, exp);
    end
  endtask

  // Drive one cycle at the negedge, then check all three outputs one cycle later
  task automatic step(input string req, input logic we, input logic [AW-1:0] wa,
                      input logic [WIDTH-1:0] wd, input logic re,
                      input logic [AW-1:0] ra);
    logic [WIDTH-1:0] e_wf, e_ro, e_ud;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    e_wf = exp_for(RUW_WRITE_NEW, we, wa, wd, re, ra, ref_mem[ra]);
    e_ro = exp_for(RUW_READ_OLD,  we, wa, wd, re, ra, ref_mem[ra]);
    e_ud = exp_for(RUW_UNSPEC,    we, wa, wd, re, ra, ref_mem[ra]);
    if (we) ref_mem[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    check(req, "write_new", q_wf, e_wf);
    check(req, "read_old",  q_ro, e_ro);
    check(req, "unspec",    q_ud, e_ud);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R4: just after reset release nothing has been read
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", "post_reset", q_wf, XV);
    check("R4", "post_reset", q_ro, XV);
    check("R4", "post_reset", q_ud, XV);

    // R1 R2: fill the whole array, no reads yet
    for (int i = 0; i < DEPTH; i++)
      step("R2", 1'b1, AW'(i), WIDTH'((i * 37 + 5) & 8'hff), 1'b0, '0);

    // R1: both ends of the address range
    step("R1", 1'b0, '0, '0, 1'b1, 8'd0);
    step("R1", 1'b0, '0, '0, 1'b1, 8'd255);
    step("R1", 1'b1, 8'd255, 8'hc3, 1'b0, '0);
    step("R1", 1'b0, '0, '0, 1'b1, 8'd255);

    // R2: write enable low leaves contents alone
    step("R2", 1'b0, 8'd10, 8'hee, 1'b0, '0);
    step("R2", 1'b0, 8'd10, 8'h11, 1'b1, 8'd10);

    // R4 then R3: enable low followed by enable high
    step("R4", 1'b0, '0, '0, 1'b0, 8'd20);
    step("R3", 1'b0, '0, '0, 1'b1, 8'd20);
    step("R4", 1'b1, 8'd20, 8'h5a, 1'b0, 8'd20);
    step("R3", 1'b0, '0, '0, 1'b1, 8'd20);

    // R6 R7 R8: single collision
    step("R6_R7_R8", 1'b1, 8'd30, 8'ha1, 1'b1, 8'd30);
    // R5: write elsewhere while reading
    step("R5", 1'b1, 8'd31, 8'hb2, 1'b1, 8'd30);

    // R9: back-to-back collisions on one address
    for (int k = 0; k < 6; k++)
      step("R9", 1'b1, 8'd40, WIDTH'(8'h10 + k * 17), 1'b1, 8'd40);
    step("R9", 1'b0, '0, '0, 1'b1, 8'd40);

    // Random phase over a small window to provoke collisions
    for (int n = 0; n < 3000; n++) begin
      logic we, re;
      logic [AW-1:0] wa, ra;
      we = ($urandom % 3) != 0;
      re = ($urandom % 4) != 0;
      wa = AW'($urandom % 6);
      ra = AW'(($urandom % 2) != 0 ? wa : AW'($urandom % 6));
      step("R5_R9", we, wa, WIDTH'($urandom), re, ra);
    end

    // R10: reset keeps contents, clears valid
    step("R10", 1'b1, 8'd50, 8'h7e, 1'b1, 8'd50);
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    check("R10", "in_reset", q_wf, XV);
    check("R10", "in_reset", q_ro, XV);
    rst_n = 1'b1;
    @(negedge clk);
    step("R10", 1'b0, '0, '0, 1'b1, 8'd50);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule